// File: doc/BRIEF.md
# Digital Ramp Converter Controller

This block sequences a counter-ramp analog-to-digital conversion. A start pulse clears an internal up-counter. The counter value drives an external DAC on every cycle, and the counter climbs by one per clock while an external comparator reports that the analog input is still above the DAC level. When the comparator falls to 0, the climb stops. The counter value is then captured as the result, and a one-cycle done pulse marks the end of the conversion.

The conversion time depends on the input. For an input that rounds to code k, the block stays busy for k+1 clocks. If the code reaches all-ones while the comparator still reads 1, the conversion ends at full scale and flags an overrange. The DAC, the comparator and all analog behaviour live outside the block.

Top module: `ramp_adc`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), busy_o, done_o and ovr_o are 0, and code_o and result_o are all zeros.
- R2: A start_i sampled high while idle sets code_o to 0 and busy_o to 1 after that clock edge.
- R3: While busy_o is 1, cmp_i is 1 and code_o is below all-ones, code_o increases by exactly one on each clock.
- R4: A clock edge with busy_o at 1 and cmp_i at 0 ends the conversion. After that edge, busy_o is 0, result_o equals the code present at the edge, and ovr_o is 0. For an input value k within range, busy_o stays high for k+1 cycles.
- R5: done_o is high for exactly one cycle, in the first cycle after a conversion ends. It is never high together with busy_o.
- R6: A clock edge with busy_o at 1, cmp_i at 1 and code_o at all-ones ends the conversion. result_o becomes all-ones and ovr_o becomes 1. An input equal to all-ones ends on the comparator instead, with ovr_o at 0.
- R7: A start_i that arrives while busy_o is 1 has no effect: the count keeps climbing and the result is unchanged.
- R8: Between conversions, code_o holds its final value, and result_o and ovr_o hold until the next conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator output, 1 while the analog input is above the DAC level |
| code_o | output | WIDTH | Counter value driving the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | WIDTH | Captured conversion result |
| ovr_o | output | 1 | Last conversion ended at full scale with the comparator still high |

## Verification
The hardest situation to reach from the ports is the full-scale end. The counter must walk through every code up to all-ones while the comparator stays high. Right at that boundary, the block must tell an input exactly equal to all-ones (a comparator stop with no overrange) from one above it (an overrange stop).

The bench's behavioural comparator model compares a numeric input against code_o in the same cycle. Driving it with the all-ones value and with a larger value walks the ramp all the way to the top. A start pulse injected in the middle of a long ramp and a reset applied in the middle of a ramp cover the ignore and abort paths.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cmp_i,
  input  logic at_max_i,
  output logic clr_o,
  output logic inc_o,
  output logic stop_o,
  output logic ovr_hit_o,
  output logic busy_o
);
  ramp_state_e state_q, state_d;

  logic run;
  assign run       = (state_q == ST_RUN);
  assign clr_o     = (state_q == ST_IDLE) && start_i;
  assign inc_o     = run && cmp_i && !at_max_i;
  assign ovr_hit_o = run && cmp_i && at_max_i;
  assign stop_o    = run && (!cmp_i || at_max_i);
  assign busy_o    = run;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (stop_o)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R5
  single_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_o && stop_o) && !(inc_o && stop_o));
endmodule

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             at_max_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;

  // R2
  clear_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ramp_adc_capture.sv
module ramp_adc_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ovr_hit_i,
  input  logic [WIDTH-1:0] cnt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        result_o <= cnt_i;
        ovr_o    <= ovr_hit_i;
      end
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(result_o) && $stable(ovr_o));
endmodule

// File: rtl/ramp_adc.sv
module ramp_adc #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             ovr_o
);
  localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};

  logic clr, inc, stop, ovr_hit, at_max;

  ramp_adc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .at_max_i  (at_max),
    .clr_o     (clr),
    .inc_o     (inc),
    .stop_o    (stop),
    .ovr_hit_o (ovr_hit),
    .busy_o    (busy_o)
  );

  ramp_adc_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .inc_i    (inc),
    .cnt_o    (code_o),
    .at_max_o (at_max)
  );

  ramp_adc_capture #(.WIDTH(WIDTH)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (stop),
    .ovr_hit_i (ovr_hit),
    .cnt_i     (code_o),
    .result_o  (result_o),
    .ovr_o     (ovr_o),
    .done_o    (done_o)
  );

  // R3
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmp_i && code_o != CODE_MAX) |=> busy_o && code_o == $past(code_o) + 1'b1);

  // R4
  cmp_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmp_i) |=> !busy_o && done_o && !ovr_o && result_o == $past(code_o));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o ##1 !done_o);

  // R6
  full_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmp_i && code_o == CODE_MAX) |=> done_o && ovr_o && result_o == CODE_MAX);

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && cmp_i && code_o != CODE_MAX) |=> code_o != '0);
endmodule

// File: tb/ramp_adc_tb_top.sv
module ramp_adc_tb_top;
  localparam int WIDTH    = 8;
  localparam int CODE_MAX = (1 << WIDTH) - 1;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [WIDTH-1:0] code, result;
  logic busy, done, ovr;
  int vin = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural comparator: 1 while analog input exceeds DAC level
  assign cmp = (vin > int'(code));

  ramp_adc #(.WIDTH(WIDTH)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .cmp_i    (cmp),
    .code_o   (code),
    .busy_o   (busy),
    .done_o   (done),
    .result_o (result),
    .ovr_o    (ovr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one conversion; inject>0 raises start during busy cycle number inject
  task automatic run_conv(input int v, input int inject);
    int cycles, prev, exp, guard;
    bit step_ok;
    exp = (v > CODE_MAX) ? CODE_MAX : v;
    @(negedge clk);
    vin = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    check(code == '0, "R2 code cleared", int'(code), 0);
    cycles = 1;
    step_ok = 1;
    guard = 0;
    while (busy && guard < 1000) begin
      prev = int'(code);
      start = (inject > 0 && cycles == inject);
      @(negedge clk);
      start = 1'b0;
      guard++;
      if (busy) begin
        cycles++;
        if (int'(code) != prev + 1) step_ok = 0;
      end
    end
    check(step_ok, "R3 ramp step", int'(code), prev + 1);
    check(done == 1'b1, "R5 done after end", int'(done), 1);
    check(int'(result) == exp, (v > CODE_MAX) ? "R6 full-scale result" : "R4 result",
          int'(result), exp);
    check(ovr == (v > CODE_MAX), (v > CODE_MAX) ? "R6 ovr set" : "R6 ovr clear",
          int'(ovr), int'(v > CODE_MAX));
    check(cycles == exp + 1, (inject > 0) ? "R7 busy length" : "R4 busy length",
          cycles, exp + 1);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", int'(done), 0);
    check(int'(code) == exp, "R8 code held", int'(code), exp);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && ovr == 0, "R1 reset flags",
          int'({busy, done, ovr}), 0);
    check(code == '0 && result == '0, "R1 reset codes", int'(code) + int'(result), 0);
  endtask

  task automatic t_hold();
    int r0;
    r0 = int'(result);
    vin = 3;
    repeat (5) @(negedge clk);
    check(int'(result) == r0 && !busy, "R8 result held", int'(result), r0);
    check(ovr == 1'b0, "R8 ovr held", int'(ovr), 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    vin = 200;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 0 && code == '0, "R1 reset mid-run", int'(code), 0);
    check(result == '0 && done == 0 && ovr == 0, "R1 reset clears result",
          int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG_CYCLES) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <= %0d", cyc, WATCHDOG_CYCLES);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_conv(0, 0);
    run_conv(1, 0);
    run_conv(37, 0);
    t_hold();
    run_conv(CODE_MAX, 0);
    run_conv(CODE_MAX + 45, 0);
    run_conv(100, 20);
    run_conv(60, 1);
    t_reset_mid();
    t_reset();
    run_conv(12, 0);
    finished = 1;
    summary();
  end
endmodule